// File: doc/BRIEF.md
# Programmable-Priority Highest-Pending Resolver

This block sits beside an interrupt controller and answers one question every cycle: among the sources that are both pending and enabled, which one has the best priority? It answers twice, once for sources steered to the fast interrupt class and once for those steered to the normal class. Priority does not follow source number. A table of 40 slots, written by software, ranks the sources: slot 0 is ranked first and slot 39 last. Each slot holds a source ID and a flag that says whether the slot takes part.

Software fills the table through a small register port. The same port reads slots back. The controller feeds the three 40-bit source vectors: enable, pending and class select. The resolver returns a registered 32-bit status word. Its upper half names the normal-class winner and its lower half names the fast-class winner. Each half has its own found flag.

Top module: `prio_resolver`

## Requirements
- R1: A write to a slot stores only data bit 31 (the flag that makes the slot take part) and data bits 5:0 (the source ID). A read of a slot returns those bits in the same positions, and every other bit reads 0.
- R2: Slot k (k < 32) lives at byte address 0x1C + 4k. Slot k (32 ≤ k < 40) lives at 0xB0 + 4(k−32). Any other address, including one that is not a multiple of 4, reads 0. A write to such an address changes no slot.
- R3: A slot takes part only when its flag is 1 and its source ID is below 40. Otherwise the slot is skipped.
- R4: A source counts as live when its pending bit and its enable bit are both 1. A live source with class-select bit 1 competes for the fast half. A live source with class-select bit 0 competes for the normal half.
- R5: In each half, the lowest-numbered taking-part slot whose source is live in that half decides the winner. The same source ID may appear in several slots.
- R6: The status word carries the normal-class found flag in bit 31 and the normal-class ID in bits 21:16. It carries the fast-class found flag in bit 15 and the fast-class ID in bits 5:0. Bits 30:22 and 14:6 are always 0.
- R7: A half with no winner shows ID 0x3F with its found flag 0. With no winner in either half, the word is 0x003F003F.
- R8: The status word updates at the first clock edge after a change of the source vectors, or after a table write takes effect. Between edges it holds its value.
- R9: While reset (rst_n low) is held, every slot clears to 0 and the status word reads 0x003F003F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_wr | input | 1 | Write strobe for the slot table |
| tbl_addr | input | 8 | Byte address for a table read or write |
| tbl_wdata | input | 32 | Write data |
| tbl_rdata | output | 32 | Slot read data (combinational from tbl_addr) |
| src_enable | input | 40 | Per-source enable |
| src_pending | input | 40 | Per-source pending |
| src_fiq_sel | input | 40 | Per-source class select (1 = fast class) |
| winner_word | output | 32 | Registered status word |

## Verification
The properties assume that the source vectors are stable around the clock edge. They also assume that a winner ID can be traced back to a vector bit as it stood one edge earlier, which holds only when the inputs are not X. The bench drives the vectors and the table port only at falling edges and always with known values. It programs the table with source IDs over the full 6-bit range, so slots with IDs of 40 or more and repeated IDs do occur. The sweeps cover single live sources of each class, exhaustive slot read-back, and pseudo-random tables and vectors.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;

  localparam int ID_W = 6;
  localparam logic [ID_W-1:0] NO_ID = '1;

  typedef struct packed {
    logic            vld;
    logic [ID_W-1:0] id;
  } slot_t;

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } pick_t;

  function automatic logic [31:0] pack_word(input pick_t nrm, input pick_t fst);
    return {nrm.found, 9'b0, nrm.id, fst.found, 9'b0, fst.id};
  endfunction

  function automatic logic [31:0] slot_to_word(input slot_t s);
    return {s.vld, 25'b0, s.id};
  endfunction

endpackage

// File: rtl/prio_table.sv
module prio_table
  import prio_res_pkg::*;
#(
  parameter int N_SLOT  = 40,
  parameter int N_LO    = 32,
  parameter int LO_BASE = 'h1C,
  parameter int HI_BASE = 'hB0,
  parameter int AW      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output slot_t [N_SLOT-1:0]      slots
);

  localparam int IDX_W  = $clog2(N_SLOT);
  localparam int LO_END = LO_BASE + 4 * N_LO;
  localparam int HI_END = HI_BASE + 4 * (N_SLOT - N_LO);

  logic             hit;
  logic [IDX_W-1:0] idx;
  int               a;
  int               idx_i;

  // Address decode: two windows of word-aligned slots
  always_comb begin
    a     = int'(addr);
    hit   = 1'b0;
    idx_i = 0;
    if (addr[1:0] == 2'b00) begin
      if (a >= LO_BASE && a < LO_END) begin
        hit   = 1'b1;
        idx_i = (a - LO_BASE) / 4;
      end else if (a >= HI_BASE && a < HI_END) begin
        hit   = 1'b1;
        idx_i = N_LO + (a - HI_BASE) / 4;
      end
    end
    idx = IDX_W'(idx_i);
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (wr_en && hit && idx == IDX_W'(g)) begin
        slots[g] <= '{vld: wdata[31], id: wdata[ID_W-1:0]};
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = slot_to_word(slots[idx]);
  end

endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import prio_res_pkg::*;
#(
  parameter int N_SLOT = 40,
  parameter int N_SRC  = 40
) (
  input  slot_t [N_SLOT-1:0] slots,
  input  logic [N_SRC-1:0]   cand,
  output pick_t              winner
);

  logic [63:0] cand_w;
  assign cand_w = 64'(cand);

  // Scan from the lowest rank upward so that slot 0 overrides all others
  always_comb begin
    winner = '{found: 1'b0, id: NO_ID};
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (slots[i].vld && int'(slots[i].id) < N_SRC && cand_w[slots[i].id]) begin
        winner = '{found: 1'b1, id: slots[i].id};
      end
    end
  end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
#(
  parameter int N_SRC   = 40,
  parameter int N_SLOT  = 40,
  parameter int N_LO    = 32,
  parameter int LO_BASE = 'h1C,
  parameter int HI_BASE = 'hB0,
  parameter int AW      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_wr,
  input  logic [AW-1:0]    tbl_addr,
  input  logic [31:0]      tbl_wdata,
  output logic [31:0]      tbl_rdata,
  input  logic [N_SRC-1:0] src_enable,
  input  logic [N_SRC-1:0] src_pending,
  input  logic [N_SRC-1:0] src_fiq_sel,
  output logic [31:0]      winner_word
);

  localparam int N_CLASS = 2;  // index 0: normal class, 1: fast class

  slot_t [N_SLOT-1:0] slots;
  logic  [N_SRC-1:0]  live;
  pick_t              picks [N_CLASS];

  prio_table #(
    .N_SLOT (N_SLOT),
    .N_LO   (N_LO),
    .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE),
    .AW     (AW)
  ) u_table (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(tbl_wr),
    .addr (tbl_addr),
    .wdata(tbl_wdata),
    .rdata(tbl_rdata),
    .slots(slots)
  );

  assign live = src_pending & src_enable;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    logic [N_SRC-1:0] cand;
    assign cand = (c == 1) ? (live & src_fiq_sel) : (live & ~src_fiq_sel);

    prio_pick #(
      .N_SLOT(N_SLOT),
      .N_SRC (N_SRC)
    ) u_pick (
      .slots (slots),
      .cand  (cand),
      .winner(picks[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) winner_word <= pack_word('{1'b0, NO_ID}, '{1'b0, NO_ID});
    else        winner_word <= pack_word(picks[0], picks[1]);
  end

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int N_SRC = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      tbl_rdata,
  input logic [N_SRC-1:0] src_enable,
  input logic [N_SRC-1:0] src_pending,
  input logic [N_SRC-1:0] src_fiq_sel,
  input logic [31:0]      winner_word
);

  logic [63:0] nrm_prev;
  logic [63:0] fst_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrm_prev <= '0;
      fst_prev <= '0;
    end else begin
      nrm_prev <= 64'(src_pending & src_enable & ~src_fiq_sel);
      fst_prev <= 64'(src_pending & src_enable & src_fiq_sel);
    end
  end

  p_rdata_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rdata[30:6] == '0);

  p_nrm_id_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    winner_word[31] |-> (int'(winner_word[21:16]) < N_SRC));

  p_fst_id_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    winner_word[15] |-> (int'(winner_word[5:0]) < N_SRC));

  p_nrm_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    winner_word[31] |-> nrm_prev[winner_word[21:16]]);

  p_fst_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    winner_word[15] |-> fst_prev[winner_word[5:0]]);

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    winner_word[30:22] == '0 && winner_word[14:6] == '0);

  p_nrm_empty_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !winner_word[31] |-> winner_word[21:16] == 6'h3F);

  p_fst_empty_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !winner_word[15] |-> winner_word[5:0] == 6'h3F);

  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pending & src_enable) == '0 |=> winner_word == 32'h003F003F);

endmodule

bind prio_resolver prio_resolver_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tbl_rdata  (tbl_rdata),
  .src_enable (src_enable),
  .src_pending(src_pending),
  .src_fiq_sel(src_fiq_sel),
  .winner_word(winner_word)
);

// File: tb/test_prio_resolver.sv
`timescale 1ns/1ps
module test_prio_resolver;

  localparam int NS = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tbl_wr = 1'b0;
  logic [7:0]    tbl_addr = '0;
  logic [31:0]   tbl_wdata = '0;
  logic [31:0]   tbl_rdata;
  logic [NS-1:0] src_enable = '0;
  logic [NS-1:0] src_pending = '0;
  logic [NS-1:0] src_fiq_sel = '0;
  logic [31:0]   winner_word;

  int total = 0;
  int bad = 0;
  logic [31:0] mtab [NS];
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;  // 250 MHz

  prio_resolver i_prio_resolver (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .src_enable(src_enable),
    .src_pending(src_pending), .src_fiq_sel(src_fiq_sel), .winner_word(winner_word)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic logic [7:0] addr_of(input int k);
    return (k < 32) ? 8'(8'h1C + 4 * k) : 8'(8'hB0 + 4 * (k - 32));
  endfunction

  // Expected status word from requirements R3..R7
  function automatic logic [31:0] model(input logic [NS-1:0] en, input logic [NS-1:0] pd,
                                         input logic [NS-1:0] fq);
    logic [5:0] nid = 6'h3F, fid = 6'h3F;
    logic nv = 1'b0, fv = 1'b0;
    for (int i = NS - 1; i >= 0; i--) begin
      int id = int'(mtab[i][5:0]);
      if (mtab[i][31] && id < NS && en[id] && pd[id]) begin
        if (fq[id]) begin fv = 1'b1; fid = 6'(id); end
        else        begin nv = 1'b1; nid = 6'(id); end
      end
    end
    return {nv, 9'b0, nid, fv, 9'b0, fid};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic wr_slot(input int k, input logic [31:0] d);
    wr(addr_of(k), d);
    mtab[k] = d & 32'h8000_003F;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    tbl_addr = a;
    #0.5;
    chk(tbl_rdata, exp, req);
  endtask

  task automatic drive(input logic [NS-1:0] en, input logic [NS-1:0] pd,
                       input logic [NS-1:0] fq, input string req);
    @(negedge clk);
    src_enable = en; src_pending = pd; src_fiq_sel = fq;
    @(negedge clk);
    chk(winner_word, model(en, pd, fq), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    logic [NS-1:0] ones;
    ones = '1;
    for (int k = 0; k < NS; k++) mtab[k] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(winner_word, 32'h003F003F, "R9 reset word");
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NS; k++) rd_chk(addr_of(k), 32'h0, "R9 slot clear");
    chk(winner_word, 32'h003F003F, "R7 idle word");

    // R1, R2: masked writes and full address map
    for (int k = 0; k < NS; k++)
      wr_slot(k, 32'h7FFF_FFC0 | (32'(k & 1) << 31) | 32'(k));
    for (int k = 0; k < NS; k++) rd_chk(addr_of(k), mtab[k], "R1 R2 slot readback");

    // R2: unmapped or misaligned addresses read 0 and change nothing
    begin
      logic [7:0] bad_a [8] = '{8'h00, 8'h18, 8'h1D, 8'h9A, 8'h9C, 8'hAC, 8'hD0, 8'hFC};
      for (int j = 0; j < 8; j++) begin
        wr(bad_a[j], 32'hFFFF_FFFF);
        rd_chk(bad_a[j], 32'h0, "R2 unmapped read");
      end
      for (int k = 0; k < NS; k++) rd_chk(addr_of(k), mtab[k], "R2 unmapped write ignored");
    end

    // R4, R6: reversed table, one live source at a time in each class
    for (int k = 0; k < NS; k++) wr_slot(k, 32'h8000_0000 | 32'(NS - 1 - k));
    for (int s = 0; s < NS; s++) begin
      logic [NS-1:0] b;
      b = NS'(1) << s;
      drive(b, b, '0, "R4 R6 normal single");
      chk(winner_word, {1'b1, 9'b0, 6'(s), 1'b0, 9'b0, 6'h3F}, "R6 normal layout");
      drive(b, b, b, "R4 R6 fast single");
      chk(winner_word, {1'b0, 9'b0, 6'h3F, 1'b1, 9'b0, 6'(s)}, "R6 fast layout");
    end
    drive('0, ones, '0, "R4 pending without enable");
    chk(winner_word, 32'h003F003F, "R7 nothing enabled");
    drive(ones, '0, ones, "R4 enable without pending");
    chk(winner_word, 32'h003F003F, "R7 nothing pending");
    drive(ones, ones, '0, "R5 all live normal");
    chk(winner_word, 32'h8027003F, "R5 slot0 wins");

    // R3, R5: skipped slots and repeated IDs
    for (int k = 0; k < NS; k++) wr_slot(k, 32'h0);
    wr_slot(0, 32'h8000_002D);  // ID 45, out of range
    wr_slot(1, 32'h0000_0003);  // flag clear
    wr_slot(2, 32'h8000_0007);
    wr_slot(5, 32'h8000_0003);
    wr_slot(9, 32'h8000_0007);  // repeated ID
    drive(ones, ones, '0, "R3 skip invalid slots");
    chk(winner_word, 32'h8007003F, "R3 R5 normal winner 7");
    drive(ones, ones, NS'(1) << 7, "R5 split classes");
    chk(winner_word, 32'h80038007, "R5 fast 7 normal 3");

    // R8: one-edge latency, value held between edges
    drive('0, '0, '0, "R8 idle");
    prev = winner_word;
    @(negedge clk);
    src_enable = ones; src_pending = ones; src_fiq_sel = '0;
    #1;
    chk(winner_word, prev, "R8 holds before edge");
    @(negedge clk);
    chk(winner_word, 32'h8007003F, "R8 updates after edge");
    wr_slot(0, 32'h8000_0011);
    chk(winner_word, 32'h8007003F, "R8 write not yet visible");
    @(negedge clk);
    chk(winner_word, 32'h8011003F, "R8 write visible one edge later");

    // R3, R4, R5: pseudo-random tables and vectors
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < NS; k++) begin
        logic [63:0] v;
        v = rnd();
        wr_slot(k, {(v[9:8] != 2'b00), 25'b0, v[5:0]});
      end
      for (int t = 0; t < 50; t++) begin
        logic [63:0] e, p, f;
        e = rnd(); p = rnd(); f = rnd();
        if (t[0]) begin e = e & rnd(); p = p & rnd(); end
        drive(NS'(e), NS'(p), NS'(f), "R3 R4 R5 random sweep");
      end
    end

    // R9: reset again clears table and word
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(winner_word, 32'h003F003F, "R9 word under reset");
    rd_chk(addr_of(0), 32'h0, "R9 table under reset");
    rd_chk(addr_of(39), 32'h0, "R9 table under reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule